// File: doc/BRIEF.md
# Prescaled Eight-Bit PWM Timer

This block generates a single pulse-width-modulated output from a slow timing enable, nominally 32 kHz. An eight-bit counter advances once per enable pulse. A two-bit prescaler chooses the counter's full-scale range, 128, 64, 32 or 16 counts. That range gives output rates of 250 Hz, 500 Hz, 1 kHz or 2 kHz from a 32 kHz enable. The output is high while the masked count is below a seven-bit duty value.

Software reaches the block through a byte-wide register port with one address bit, in two independent writes: a control register and a duty register. No write is shadowed. A new prescaler or a new duty value acts in the cycle after the write, without restarting the count. While the timer is disabled, the output pin carries a general-purpose level supplied from outside.

Top module: `pwm_prescaled8`

## Requirements
- R1: A synchronous active-high reset clears the control register, the duty register and the counter, so both registers read 0x00 and the output follows `gpio_in`.
- R2: Address 0 is the control register: bit 7 is enable and bits [1:0] are the prescaler p. Bits [6:2] are not stored and read as zero.
- R3: Address 1 is the duty register, which holds bits [6:0] of the written byte. Bit 7 reads as zero.
- R4: The counter changes only on a cycle with `tick` high. With full scale FS = 2^(7-p), the counter wraps to 0 on a tick when its value is FS-1 or larger, and otherwise increments by one. The period is therefore FS ticks.
- R5: While enabled, `pwm_out` is high exactly when (counter AND (FS-1)) < duty. Over one period it is high for min(duty, FS) ticks.
- R6: A duty value of FS or more holds `pwm_out` high while enabled. With p = 0, the largest duty (127) gives 127 high ticks out of 128.
- R7: While enable is 0, `pwm_out` equals `gpio_in` in the same cycle.
- R8: A duty write takes effect in the cycle after its write edge. It does not clear or alter the counter.
- R9: A prescaler write does not clear the counter. If the count is at or above the new FS-1, it wraps to 0 on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable, one cycle per timer step |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 duty |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, combinational |
| gpio_in | input | 1 | Level driven on the pin while disabled |
| pwm_out | output | 1 | Pin output |

## Verification
Register contents and the counter are each one flop stage from their inputs, and the read path and output path are combinational from those flops. A write or tick applied before a rising edge is therefore visible on `reg_rdata` and `pwm_out` in the same clock cycle after that edge. The bench drives and samples on falling edges, so every result is read half a cycle after the edge that produced it. The `gpio_in` bypass has no register, so it is checked a settle delay after the input changes. Waveform-level checks count high samples over exactly FS consecutive ticks, with `tick` held high. Counter position is inferred through duty thresholds after single-tick steps.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int CNT_W  = 8;
    localparam int PSC_W  = 2;
    localparam int DUTY_W = CNT_W - 1;
    localparam int DATA_W = 8;
    localparam int EN_BIT = DATA_W - 1;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DUTY = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             en;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

    // Full-scale count for a prescaler: 2^(CNT_W-1-p)
    function automatic logic [CNT_W-1:0] full_scale(input logic [PSC_W-1:0] p);
        return CNT_W'(1) << (CNT_W - 1 - int'(p));
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [DUTY_W-1:0] duty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            duty <= '0;
        end else if (wr) begin
            if (reg_sel_e'(addr) == SEL_CTRL) begin
                ctrl.en  <= wdata[EN_BIT];
                ctrl.psc <= wdata[PSC_W-1:0];
            end else begin
                duty <= wdata[DUTY_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (reg_sel_e'(addr) == SEL_CTRL) begin
            rdata[EN_BIT]      = ctrl.en;
            rdata[PSC_W-1:0]   = ctrl.psc;
        end else begin
            rdata[DUTY_W-1:0]  = duty;
        end
    end

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PSC_W-1:0] psc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] last_val;

    // Highest in-range value; anything at or above it wraps
    assign last_val = full_scale(psc) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt >= last_val) cnt <= '0;
            else                 cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwmt_compare.sv
module pwmt_compare
    import pwmt_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic [DUTY_W-1:0] duty,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              gpio_in,
    output logic              pin
);

    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] phase;
    logic             level;

    assign mask  = full_scale(ctrl.psc) - CNT_W'(1);
    assign phase = cnt & mask;
    assign level = {1'b0, duty} > phase;
    assign pin   = ctrl.en ? level : gpio_in;

endmodule

// File: rtl/pwm_prescaled8.sv
module pwm_prescaled8
    import pwmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              gpio_in,
    output logic              pwm_out
);

    ctrl_t             ctrl_q;
    logic [DUTY_W-1:0] duty_q;
    logic [CNT_W-1:0]  cnt_q;

    pwmt_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl_q),
        .duty  (duty_q)
    );

    pwmt_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .psc  (ctrl_q.psc),
        .cnt  (cnt_q)
    );

    pwmt_compare u_cmp (
        .ctrl    (ctrl_q),
        .duty    (duty_q),
        .cnt     (cnt_q),
        .gpio_in (gpio_in),
        .pin     (pwm_out)
    );

endmodule

// File: rtl/pwm_prescaled8_chk.sv
module pwm_prescaled8_chk
    import pwmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              gpio_in,
    input logic              pwm_out,
    input ctrl_t             ctrl_q,
    input logic [DUTY_W-1:0] duty_q,
    input logic [CNT_W-1:0]  cnt_q
);

    logic [CNT_W-1:0] fs;
    assign fs = full_scale(ctrl_q.psc);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && duty_q == '0 && ctrl_q == '0));

    p_ctrl_gaps_r2: assert property (@(posedge clk) disable iff (rst)
        !reg_addr |-> reg_rdata[EN_BIT-1:PSC_W] == '0);

    p_duty_msb_r3: assert property (@(posedge clk) disable iff (rst)
        reg_addr |-> !reg_rdata[EN_BIT]);

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q >= fs - CNT_W'(1)) |=> cnt_q == '0);

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q < fs - CNT_W'(1)) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    p_full_high_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && {1'b0, duty_q} >= fs) |-> pwm_out);

    p_gpio_path_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |-> pwm_out == gpio_in);

    p_duty_load_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr) |=> duty_q == $past(reg_wdata[DUTY_W-1:0]));

endmodule

bind pwm_prescaled8 pwm_prescaled8_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .gpio_in   (gpio_in),
    .pwm_out   (pwm_out),
    .ctrl_q    (ctrl_q),
    .duty_q    (duty_q),
    .cnt_q     (cnt_q)
);

// File: tb/pwm_prescaled8_test.sv
`timescale 1ns/1ps
module pwm_prescaled8_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       gpio_in = 1'b0;
    logic       pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pwm_prescaled8 uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gpio_in   (gpio_in),
        .pwm_out   (pwm_out)
    );

    // {prescaler, duty, expected high ticks in one period}
    localparam int NV = 13;
    localparam int VEC [NV][3] = '{
        '{0,   0,   0}, '{0,   1,   1}, '{0,  64,  64}, '{0, 127, 127},
        '{1,  32,  32}, '{1,  64,  64}, '{1, 100,  64},
        '{2,   5,   5}, '{2,  32,  32},
        '{3,   0,   0}, '{3,  15,  15}, '{3,  16,  16}, '{3, 127,  16}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_chk(input logic a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #0.5;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic out_chk(input logic exp, input string req);
        #0.5;
        check(pwm_out == exp, req, pwm_out, exp);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state
        read_chk(1'b0, 8'h00, "R1 ctrl after reset");
        read_chk(1'b1, 8'h00, "R1 duty after reset");
        gpio_in = 1'b1; out_chk(1'b1, "R1 out follows gpio");
        gpio_in = 1'b0; out_chk(1'b0, "R1 out follows gpio");

        // R2 / R3: field storage and zero bits
        write_reg(1'b0, 8'h7C);
        read_chk(1'b0, 8'h00, "R2 unused ctrl bits");
        write_reg(1'b0, 8'hFF);
        read_chk(1'b0, 8'h83, "R2 ctrl fields");
        write_reg(1'b1, 8'hFF);
        read_chk(1'b1, 8'h7F, "R3 duty width");

        // R5 / R6: vector table, tick every cycle
        @(negedge clk); tick = 1'b1;
        for (int v = 0; v < NV; v++) begin
            int fsv;
            int hi;
            fsv = 1 << (7 - VEC[v][0]);
            write_reg(1'b0, 8'(8'h80 | VEC[v][0]));
            write_reg(1'b1, 8'(VEC[v][1]));
            repeat (2) @(negedge clk);
            hi = 0;
            for (int s = 0; s < fsv; s++) begin
                #0.5;
                if (pwm_out) hi++;
                @(negedge clk);
            end
            check(hi == VEC[v][2], (VEC[v][1] >= fsv) ? "R6 high ticks" : "R5 high ticks",
                  hi, VEC[v][2]);
        end
        @(negedge clk); tick = 1'b0;

        // R8: duty acts at once, counter untouched
        do_reset();
        write_reg(1'b0, 8'h83);
        out_chk(1'b0, "R5 duty 0 low");
        write_reg(1'b1, 8'h01);
        out_chk(1'b1, "R8 new duty immediate");
        ticks(5);
        out_chk(1'b0, "R5 count 5 vs duty 1");
        write_reg(1'b1, 8'h06);
        out_chk(1'b1, "R8 count kept at 5, duty 6");
        write_reg(1'b1, 8'h05);
        out_chk(1'b0, "R8 count kept at 5, duty 5");

        // R4: no tick means no count; wrap after FS-1
        write_reg(1'b1, 8'h01);
        repeat (10) @(negedge clk);
        out_chk(1'b0, "R4 held without tick");
        ticks(10);
        out_chk(1'b0, "R4 count 15 before wrap");
        ticks(1);
        out_chk(1'b1, "R4 wrap to 0 after 16-tick period");

        // R9: prescaler change keeps count, wraps on next tick
        do_reset();
        write_reg(1'b0, 8'h80);
        write_reg(1'b1, 8'd5);
        ticks(26);
        out_chk(1'b0, "R9 count 26 under p0");
        write_reg(1'b0, 8'h83);
        out_chk(1'b0, "R9 count not cleared by prescaler write");
        ticks(1);
        out_chk(1'b1, "R9 out-of-range count wraps on next tick");

        // R7: disabled output is the gpio level
        write_reg(1'b0, 8'h03);
        gpio_in = 1'b1; out_chk(1'b1, "R7 gpio high");
        gpio_in = 1'b0; out_chk(1'b0, "R7 gpio low");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule